// File: doc/BRIEF.md
# Reaction Timer Controller

This block runs a one-player reflex test. A start request lights a red cue for a fixed number of clock ticks. The cue then turns green, and an elapsed counter starts counting up from zero. The player answers with a react press. That press stops the counter, turns both lights off, and holds the count for display. A react press while the red cue is still lit counts as a false start, and the block returns to idle without a result.

The count leaves the block whole and also as an upper and a lower nibble, ready for two hex seven-segment decoders. Button inputs are synchronous levels. Reset is synchronous and active high, and it returns the block to idle from any state.

Top module: `reaction_timer`

## Requirements
- R1: In the cycle after reset, both LEDs are off and `elapsed` is 0.
- R2: A start press in idle lights the red LED on the next cycle and clears `elapsed` to 0. A react press in idle is ignored.
- R3: The red LED stays on for exactly `WAIT_TICKS` cycles. On the following cycle the green LED turns on, the red LED turns off and `elapsed` is 0. Start presses during red have no effect on this timing.
- R4: A react press while red is lit turns both LEDs off on the next cycle, leaves `elapsed` at 0, and no green phase follows.
- R5: While green is lit, `elapsed` rises by exactly 1 in each cycle where neither button is asserted, and holds in a cycle where start is asserted.
- R6: A react press while green is lit turns both LEDs off on the next cycle and freezes `elapsed`. Later react presses do not change it.
- R7: `elapsed` saturates at 255 and never wraps to 0.
- R8: A start press while a result is held begins a new round: red turns on and `elapsed` clears to 0.
- R9: `digit_hi` always equals `elapsed[7:4]` and `digit_lo` always equals `elapsed[3:0]`.
- R10: Reset wins over any button, in any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_btn | input | 1 | Start request level |
| react_btn | input | 1 | Player response level |
| red_led | output | 1 | Wait cue |
| green_led | output | 1 | Go cue |
| elapsed | output | CNT_W (8) | Reaction count |
| digit_hi | output | CNT_W/2 (4) | Upper nibble for a display |
| digit_lo | output | CNT_W/2 (4) | Lower nibble for a display |

## Verification
A wrong state shows up on the LEDs one cycle after the button that caused it. A stuck or early wait timer moves the green edge away from cycle `WAIT_TICKS`. A counter fault breaks the expected count in the first green cycle where it occurs, because every such cycle is compared against its arithmetic value. A missed freeze or a wrap shows up one cycle after the react press, or at the 256th counting cycle.

// File: rtl/rt_pkg.sv
package rt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_GO   = 2'd2,
        ST_HOLD = 2'd3
    } rt_state_e;

    typedef struct packed {
        logic red;
        logic green;
    } rt_lamps_t;

    function automatic rt_lamps_t lamps_of(input rt_state_e s);
        rt_lamps_t l;
        l.red   = (s == ST_WAIT);
        l.green = (s == ST_GO);
        return l;
    endfunction

endpackage

// File: rtl/rt_wait_timer.sv
module rt_wait_timer #(
    parameter int unsigned WAIT_TICKS = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic done
);
    localparam int unsigned TW = $clog2(WAIT_TICKS + 1);

    logic [TW-1:0] ticks;

    always_ff @(posedge clk) begin
        if (rst || clr)
            ticks <= '0;
        else if (run && !done)
            ticks <= ticks + 1'b1;
    end

    assign done = run && (ticks == TW'(WAIT_TICKS - 1));

    // R3: the wait count never passes its terminal value
    p_wait_bound_r3: assert property (@(posedge clk) disable iff (rst)
        ticks < TW'(WAIT_TICKS));

endmodule

// File: rtl/rt_react_counter.sv
module rt_react_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    output logic [CNT_W-1:0] q
);
    localparam logic [CNT_W-1:0] MAXV = '1;

    always_ff @(posedge clk) begin
        if (rst || clr)
            q <= '0;
        else if (en && q != MAXV)
            q <= q + 1'b1;
    end

    p_saturate_r7: assert property (@(posedge clk) disable iff (rst)
        (!clr && en && q == MAXV) |=> q == MAXV);

    p_step_r5: assert property (@(posedge clk) disable iff (rst)
        (!clr && en && q != MAXV) |=> q == CNT_W'($past(q) + 1'b1));

endmodule

// File: rtl/rt_seq.sv
module rt_seq
    import rt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start_i,
    input  logic      react_i,
    input  logic      wait_done_i,
    output rt_state_e state_o,
    output logic      wait_clr_o,
    output logic      wait_run_o,
    output logic      cnt_clr_o,
    output logic      cnt_en_o
);
    rt_state_e state, nxt;

    always_comb begin
        nxt        = state;
        wait_clr_o = 1'b0;
        wait_run_o = 1'b0;
        cnt_clr_o  = 1'b0;
        cnt_en_o   = 1'b0;
        unique case (state)
            ST_IDLE: if (start_i) begin
                nxt        = ST_WAIT;
                wait_clr_o = 1'b1;
                cnt_clr_o  = 1'b1;
            end
            ST_WAIT: begin
                wait_run_o = !react_i;
                if (react_i)          nxt = ST_IDLE;
                else if (wait_done_i) nxt = ST_GO;
            end
            ST_GO: begin
                cnt_en_o = !start_i && !react_i;
                if (react_i) nxt = ST_HOLD;
            end
            ST_HOLD: if (start_i) begin
                nxt        = ST_WAIT;
                wait_clr_o = 1'b1;
                cnt_clr_o  = 1'b1;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    assign state_o = state;

    p_reset_r10: assert property (@(posedge clk)
        rst |=> state == ST_IDLE);

    p_start_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && start_i) |=> state == ST_WAIT);

    p_early_fail_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && react_i) |=> state == ST_IDLE);

    p_stop_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_GO && react_i) |=> state == ST_HOLD);

endmodule

// File: rtl/reaction_timer.sv
module reaction_timer
    import rt_pkg::*;
#(
    parameter int unsigned WAIT_TICKS = 1000,
    parameter int unsigned CNT_W      = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_btn,
    input  logic               react_btn,
    output logic               red_led,
    output logic               green_led,
    output logic [CNT_W-1:0]   elapsed,
    output logic [CNT_W/2-1:0] digit_hi,
    output logic [CNT_W/2-1:0] digit_lo
);
    localparam int unsigned NIB_W = CNT_W / 2;

    rt_state_e state;
    rt_lamps_t lamps;
    logic      wait_clr, wait_run, wait_done, cnt_clr, cnt_en;

    rt_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_btn),
        .react_i     (react_btn),
        .wait_done_i (wait_done),
        .state_o     (state),
        .wait_clr_o  (wait_clr),
        .wait_run_o  (wait_run),
        .cnt_clr_o   (cnt_clr),
        .cnt_en_o    (cnt_en)
    );

    rt_wait_timer #(.WAIT_TICKS(WAIT_TICKS)) u_wait (
        .clk  (clk),
        .rst  (rst),
        .clr  (wait_clr),
        .run  (wait_run),
        .done (wait_done)
    );

    rt_react_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk (clk),
        .rst (rst),
        .clr (cnt_clr),
        .en  (cnt_en),
        .q   (elapsed)
    );

    assign lamps     = lamps_of(state);
    assign red_led   = lamps.red;
    assign green_led = lamps.green;
    assign digit_hi  = elapsed[CNT_W-1 -: NIB_W];
    assign digit_lo  = elapsed[NIB_W-1:0];

    p_lamps_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(red_led && green_led));

    p_freeze_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && !start_btn) |=> $stable(elapsed));

    p_red_zero_r4: assert property (@(posedge clk) disable iff (rst)
        red_led |-> elapsed == '0);

endmodule

// File: tb/tb_reaction_timer.sv
module tb_reaction_timer;
    localparam int W = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_btn = 1'b0;
    logic       react_btn = 1'b0;
    logic       red_led, green_led;
    logic [7:0] elapsed;
    logic [3:0] digit_hi, digit_lo;

    int checks = 0;
    int errors = 0;
    bit done_run = 1'b0;

    always #5 clk = ~clk;

    reaction_timer #(.WAIT_TICKS(W), .CNT_W(8)) dut (
        .clk(clk), .rst(rst), .start_btn(start_btn), .react_btn(react_btn),
        .red_led(red_led), .green_led(green_led), .elapsed(elapsed),
        .digit_hi(digit_hi), .digit_lo(digit_lo)
    );

    function automatic logic [6:0] seg7(input logic [3:0] n);
        case (n)
            4'h0: seg7 = 7'h3F; 4'h1: seg7 = 7'h06; 4'h2: seg7 = 7'h5B;
            4'h3: seg7 = 7'h4F; 4'h4: seg7 = 7'h66; 4'h5: seg7 = 7'h6D;
            4'h6: seg7 = 7'h7D; 4'h7: seg7 = 7'h07; 4'h8: seg7 = 7'h7F;
            4'h9: seg7 = 7'h6F; 4'hA: seg7 = 7'h77; 4'hB: seg7 = 7'h7C;
            4'hC: seg7 = 7'h39; 4'hD: seg7 = 7'h5E; 4'hE: seg7 = 7'h79;
            default: seg7 = 7'h71;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic state_is(input string req, input bit r, input bit g, input int e);
        check({req, " red"}, red_led, r);
        check({req, " green"}, green_led, g);
        check({req, " elapsed"}, elapsed, e);
        check("R9 hi digit", seg7(digit_hi), seg7(4'(e >> 4)));
        check("R9 lo digit", seg7(digit_lo), seg7(4'(e)));
    endtask

    task automatic tick(input bit s, input bit r);
        start_btn = s;
        react_btn = r;
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick(0, 0);
        rst = 1'b0;
    endtask

    // start and run the red phase; ends on the first green cycle
    task automatic to_green(input bit hold_start);
        tick(1, 0);
        state_is("R2 start", 1, 0, 0);
        for (int i = 1; i < W; i++) begin
            tick(hold_start, 0);
            state_is("R3 red phase", 1, 0, 0);
        end
        tick(hold_start, 0);
        state_is("R3 green edge", 0, 1, 0);
    endtask

    initial begin
        #3;
        do_reset();
        state_is("R1 reset", 0, 0, 0);
        tick(0, 1);
        state_is("R2 react in idle", 0, 0, 0);

        // R5 R6 R7: sweep reaction lengths
        for (int n = 0; n <= 300; n++) begin
            if (n > 24 && n != 254 && n != 255 && n != 256 && n != 300) continue;
            do_reset();
            to_green(0);
            for (int k = 1; k <= n; k++) begin
                tick(0, 0);
                check("R5 R7 count", elapsed, (k > 255) ? 255 : k);
            end
            tick(0, 1);
            state_is("R6 stop", 0, 0, (n > 255) ? 255 : n);
            tick(0, 1);
            tick(0, 0);
            state_is("R6 frozen", 0, 0, (n > 255) ? 255 : n);
        end

        // R4: false start at every position of the red phase
        for (int p = 0; p < W; p++) begin
            do_reset();
            tick(1, 0);
            for (int i = 0; i < p; i++) tick(0, 0);
            tick(0, 1);
            state_is("R4 false start", 0, 0, 0);
            for (int i = 0; i < W + 2; i++) begin
                tick(0, 0);
                state_is("R4 stays idle", 0, 0, 0);
            end
        end

        // R3: start held during red changes nothing
        do_reset();
        to_green(1);

        // R5: start asserted in green holds the count
        do_reset();
        to_green(0);
        tick(0, 0); tick(0, 0);
        tick(1, 0);
        check("R5 hold on start", elapsed, 2);
        tick(0, 0);
        check("R5 resume", elapsed, 3);

        // R8: new round from a held result
        tick(0, 1);
        state_is("R8 held", 0, 0, 3);
        to_green(0);
        tick(0, 0);
        check("R8 fresh count", elapsed, 1);

        // R10: reset beats buttons in green and in red
        rst = 1'b1;
        tick(1, 1);
        rst = 1'b0;
        state_is("R10 reset in green", 0, 0, 0);
        tick(1, 0);
        rst = 1'b1;
        tick(0, 1);
        rst = 1'b0;
        state_is("R10 reset in red", 0, 0, 0);

        done_run = 1'b1;
    end

    initial begin
        fork
            wait (done_run);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule